// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block fetches transmit descriptors from a ring in system memory and turns the buffers they point to into a byte stream for a MAC transmit path. Each descriptor is four 32-bit words: an ownership word, a control word that also holds the buffer size, a buffer address and a spare word. The walker takes up a descriptor only when the ownership bit shows the device owns it. It streams the buffer bytes with start-of-frame and end-of-frame markers. It then writes the ownership word back as zero to return the descriptor to the host. If the descriptor asks for it, it also raises a completion interrupt.

A descriptor flagged as a chain link carries no data. Its address word names the next descriptor, so the ring closes on itself at any length. A setup-type descriptor sends 32 words to an address-filter load port instead of the transmit stream. If the walker reaches a host-owned descriptor it suspends. A poll-demand pulse makes it read that same descriptor again. A soft-reset pulse returns it to idle. The next start then begins again at the ring base.

The byte stream is valid/ready. While `tx_valid` is high and `tx_ready` is low, the byte and its markers hold unchanged, and the walker fetches no further buffer words until the pending bytes drain. No byte is lost or repeated. Memory reads have a fixed latency of one cycle: data requested in one cycle appears on `mem_rdata` in the next.

Top module: `txring_walker`

## Requirements
- R1: After `rst_n` or a `soft_rst` pulse, `run_state` is 2'b00 (stopped), `tx_valid` is low and no memory access is issued. With `run_en` high in that state, the walker starts at the descriptor at `ring_base`.
- R2: A descriptor is processed only if bit 31 of its word 0 is set. After processing, the walker writes 0 to word 0 of that descriptor. A descriptor found with bit 31 clear is never written.
- R3: On reaching a descriptor with bit 31 clear, `run_state` becomes 2'b11 (suspended) and stays there until `poll_dmd`. It then reads the same descriptor again. Otherwise `run_state` reads 2'b01 (running).
- R4: Descriptor words sit at byte offsets 0, 4 and 8: ownership, control, buffer address. Control bits 15:0 give the byte count. Buffer bytes leave in address order, least significant byte of each word first. Buffers are word-aligned.
- R5: Control bit 31 marks a first segment and bit 30 a last segment. `tx_sof` accompanies only the first byte of a first segment, and `tx_eof` only the last byte of a last segment. Segments join in ring order.
- R6: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data`, `tx_sof` and `tx_eof` hold in the next cycle.
- R7: A descriptor with control bit 28 set emits no bytes and is not written back. The walker continues at the address in its word 2.
- R8: A descriptor with control bits 27:26 = 2'b10 sends the 32 words at its buffer address to the filter port, at `filt_addr` 0 to 31 in order. It emits no stream bytes and is then written back.
- R9: Handing back a descriptor with control bit 29 set raises `tx_irq`. A cycle with `irq_clr` high and no new event clears it; a new event wins over a clear in the same cycle.
- R10: Read and write requests never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Start the walker from idle |
| soft_rst | input | 1 | Pulse: return to idle |
| poll_dmd | input | 1 | Pulse: re-read the descriptor suspended on |
| ring_base | input | 32 | Byte address of the first descriptor |
| irq_clr | input | 1 | Write-one clear of the interrupt status |
| tx_irq | output | 1 | Transmit completion interrupt status |
| run_state | output | 2 | 00 stopped, 01 running, 11 suspended |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 32 | Read byte address |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| filt_we | output | 1 | Filter table write |
| filt_addr | output | 5 | Filter table word index |
| filt_data | output | 32 | Filter table word |

## Verification
The bench sends frames with odd byte counts, sub-word lengths and sparse ready patterns. A serializer that drops or repeats bytes under stall, or swaps the byte order within a word, shows up as a byte mismatch or a wrong count. A two-segment frame split around a chain link checks that markers appear once per frame and that the link is neither streamed nor written back. Parking on a host-owned descriptor checks that nothing moves until a poll arrives and that the same descriptor is then fetched again. A soft reset in mid-frame must restart from the ring base, not resume the old pointer. A setup descriptor must fill the filter and put nothing on the stream.

// File: rtl/txring_pkg.sv
package txring_pkg;
  // word 0
  localparam int OWN_BIT   = 31;
  // word 1 control fields
  localparam int CTL_FIRST = 31;
  localparam int CTL_LAST  = 30;
  localparam int CTL_IRQ   = 29;
  localparam int CTL_LINK  = 28;
  localparam int CTL_KIND_HI = 27;
  localparam int CTL_KIND_LO = 26;
  localparam logic [1:0] KIND_SETUP = 2'b10;

  typedef enum logic [3:0] {
    W_IDLE, W_OWN_RQ, W_OWN_RD, W_CTL_RQ, W_CTL_RD, W_ADR_RQ, W_ADR_RD,
    W_DAT_RQ, W_DAT_RD, W_DAT_EMIT, W_SET_RQ, W_SET_RD, W_GIVEBACK, W_PARK
  } walk_st_t;

  typedef enum logic [1:0] {
    RS_STOP = 2'b00,
    RS_RUN  = 2'b01,
    RS_SUSP = 2'b11
  } run_st_t;
endpackage

// File: rtl/txring_ser.sv
module txring_ser #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int IW    = $clog2(NB),
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic [CW-1:0]     nbytes,
  input  logic              sof_in,
  input  logic              eof_in,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof
);
  logic [DATA_W-1:0] wrd;
  logic [IW-1:0]     idx;
  logic [CW-1:0]     cnt;
  logic              sof_f, eof_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrd <= '0; idx <= '0; cnt <= '0; sof_f <= 1'b0; eof_f <= 1'b0; busy <= 1'b0;
    end else if (clr) begin
      busy <= 1'b0; sof_f <= 1'b0; eof_f <= 1'b0; cnt <= '0;
    end else if (load) begin
      wrd   <= word;
      idx   <= '0;
      cnt   <= nbytes;
      sof_f <= sof_in;
      eof_f <= eof_in;
      busy  <= (nbytes != '0);
    end else if (busy && out_ready) begin
      idx   <= idx + 1'b1;
      cnt   <= cnt - 1'b1;
      sof_f <= 1'b0;
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  assign out_valid = busy;
  assign out_data  = wrd[idx*BYTE_W +: BYTE_W];
  assign out_sof   = sof_f;
  assign out_eof   = eof_f && (cnt == CW'(1));

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data) &&
                                           $stable(out_sof) && $stable(out_eof)));
  // R4
  no_reload_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/txring_irq.sv
module txring_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);
  // R9
  irq_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int SIZE_W      = 16,
  parameter int SETUP_WORDS = 32,
  localparam int NB         = DATA_W / BYTE_W,
  localparam int NBC_W      = $clog2(NB) + 1,
  localparam int FILT_AW    = $clog2(SETUP_WORDS),
  localparam int DESC_BYTES = 4 * NB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               soft_rst,
  input  logic               poll_dmd,
  input  logic [ADDR_W-1:0]  ring_base,
  input  logic               irq_clr,
  output logic               tx_irq,
  output logic [1:0]         run_state,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [BYTE_W-1:0]  tx_data,
  output logic               tx_sof,
  output logic               tx_eof,
  output logic               filt_we,
  output logic [FILT_AW-1:0] filt_addr,
  output logic [DATA_W-1:0]  filt_data
);
  walk_st_t            st;
  logic [ADDR_W-1:0]   cur, ptr;
  logic                c_first, c_last, c_irq, c_link;
  logic [1:0]          c_kind;
  logic [SIZE_W-1:0]   c_size, left;
  logic                first_seg;
  logic [FILT_AW-1:0]  widx;
  logic [NBC_W-1:0]    nb;
  logic                ser_busy, ser_load, ser_sof, ser_eof, irq_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; cur <= '0; ptr <= '0; left <= '0; first_seg <= 1'b0; widx <= '0;
      c_first <= 1'b0; c_last <= 1'b0; c_irq <= 1'b0; c_link <= 1'b0;
      c_kind <= '0; c_size <= '0;
    end else if (soft_rst) begin
      st <= W_IDLE;
    end else begin
      case (st)
        W_IDLE: if (run_en) begin cur <= ring_base; st <= W_OWN_RQ; end
        W_OWN_RQ: st <= W_OWN_RD;
        W_OWN_RD: st <= mem_rdata[OWN_BIT] ? W_CTL_RQ : W_PARK;
        W_CTL_RQ: st <= W_CTL_RD;
        W_CTL_RD: begin
          c_first <= mem_rdata[CTL_FIRST];
          c_last  <= mem_rdata[CTL_LAST];
          c_irq   <= mem_rdata[CTL_IRQ];
          c_link  <= mem_rdata[CTL_LINK];
          c_kind  <= mem_rdata[CTL_KIND_HI:CTL_KIND_LO];
          c_size  <= mem_rdata[SIZE_W-1:0];
          st      <= W_ADR_RQ;
        end
        W_ADR_RQ: st <= W_ADR_RD;
        W_ADR_RD: begin
          if (c_link) begin
            cur <= mem_rdata[ADDR_W-1:0];
            st  <= W_OWN_RQ;
          end else if (c_kind == KIND_SETUP) begin
            ptr  <= mem_rdata[ADDR_W-1:0];
            widx <= '0;
            st   <= W_SET_RQ;
          end else begin
            ptr       <= mem_rdata[ADDR_W-1:0];
            left      <= c_size;
            first_seg <= 1'b1;
            st        <= (c_size == '0) ? W_GIVEBACK : W_DAT_RQ;
          end
        end
        W_DAT_RQ: st <= W_DAT_RD;
        W_DAT_RD: begin
          ptr       <= ptr + ADDR_W'(NB);
          left      <= left - SIZE_W'(nb);
          first_seg <= 1'b0;
          st        <= W_DAT_EMIT;
        end
        W_DAT_EMIT: if (!ser_busy) st <= (left == '0) ? W_GIVEBACK : W_DAT_RQ;
        W_SET_RQ: st <= W_SET_RD;
        W_SET_RD: begin
          ptr  <= ptr + ADDR_W'(NB);
          widx <= widx + 1'b1;
          st   <= (widx == FILT_AW'(SETUP_WORDS - 1)) ? W_GIVEBACK : W_SET_RQ;
        end
        W_GIVEBACK: begin
          cur <= cur + ADDR_W'(DESC_BYTES);
          st  <= W_OWN_RQ;
        end
        W_PARK: if (poll_dmd) st <= W_OWN_RQ;
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd_en = (st == W_OWN_RQ) || (st == W_CTL_RQ) || (st == W_ADR_RQ) ||
                (st == W_DAT_RQ) || (st == W_SET_RQ);
    case (st)
      W_CTL_RQ:           mem_addr = cur + ADDR_W'(NB);
      W_ADR_RQ:           mem_addr = cur + ADDR_W'(2 * NB);
      W_DAT_RQ, W_SET_RQ: mem_addr = ptr;
      default:            mem_addr = cur;
    endcase
    mem_wr_en   = (st == W_GIVEBACK);
    mem_wr_addr = cur;
    mem_wr_data = '0;
    filt_we     = (st == W_SET_RD);
    filt_addr   = widx;
    filt_data   = mem_rdata;
    nb          = (left >= SIZE_W'(NB)) ? NBC_W'(NB) : NBC_W'(left);
    ser_load    = (st == W_DAT_RD);
    ser_sof     = c_first && first_seg;
    ser_eof     = c_last && (left <= SIZE_W'(NB));
    irq_set     = (st == W_GIVEBACK) && c_irq;
    case (st)
      W_IDLE:  run_state = RS_STOP;
      W_PARK:  run_state = RS_SUSP;
      default: run_state = RS_RUN;
    endcase
  end

  txring_ser #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(ser_load),
    .word(mem_rdata), .nbytes(nb), .sof_in(ser_sof), .eof_in(ser_eof),
    .busy(ser_busy), .out_valid(tx_valid), .out_ready(tx_ready),
    .out_data(tx_data), .out_sof(tx_sof), .out_eof(tx_eof)
  );

  txring_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .irq(tx_irq)
  );

  // R10
  rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  // R1
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (run_state == RS_STOP) && !tx_valid);
  // R3
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == RS_SUSP && !poll_dmd && !soft_rst) |=> (run_state == RS_SUSP));
  // R8
  filter_not_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(filt_we && tx_valid));
endmodule

// File: tb/txring_walker_test.sv
`timescale 1ns/1ps
module txring_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, soft_rst = 1'b0, poll_dmd = 1'b0, irq_clr = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic        tx_irq;
  logic [1:0]  run_state;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wr_addr, mem_wr_data;
  logic [31:0] mem_rdata = 32'h0;
  logic        tx_valid, tx_sof, tx_eof, filt_we;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic [4:0]  filt_addr;
  logic [31:0] filt_data;

  always #2.5 clk = ~clk;

  txring_walker uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .soft_rst(soft_rst),
    .poll_dmd(poll_dmd), .ring_base(ring_base), .irq_clr(irq_clr),
    .tx_irq(tx_irq), .run_state(run_state), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .filt_we(filt_we), .filt_addr(filt_addr), .filt_data(filt_data)
  );

  localparam logic [31:0] F_FIRST = 32'h8000_0000;
  localparam logic [31:0] F_LAST  = 32'h4000_0000;
  localparam logic [31:0] F_IRQ   = 32'h2000_0000;
  localparam logic [31:0] F_LINK  = 32'h1000_0000;
  localparam logic [31:0] F_SETUP = 32'h0800_0000;
  localparam logic [31:0] OWNED   = 32'h8000_0000;

  // {byte count, ready mask, irq flag}
  localparam logic [31:0] VEC [6] = '{
    {16'd1,  8'hFF, 8'd1}, {16'd4,  8'hFF, 8'd0}, {16'd5,  8'hAA, 8'd1},
    {16'd13, 8'h92, 8'd0}, {16'd64, 8'hFF, 8'd1}, {16'd7,  8'h11, 8'd0}
  };

  logic [31:0] mem [0:255];
  logic [7:0]  cap_d [0:255];
  logic        cap_s [0:255];
  logic        cap_e [0:255];
  logic [31:0] fcap_d [0:31];
  logic [4:0]  fcap_a [0:31];
  int          cap_n = 0, fcap_n = 0, n_chk = 0, n_fail = 0;
  logic [7:0]  rdy_mask = 8'hFF;
  logic [2:0]  rdy_ph = 3'd0;

  // memory model: one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_wr_en) mem[mem_wr_addr[9:2]] <= mem_wr_data;
  end

  initial forever begin
    @(posedge clk); #1;
    rdy_ph   = rdy_ph + 3'd1;
    tx_ready = rdy_mask[rdy_ph];
  end

  initial forever begin
    @(negedge clk);
    if (tx_valid && tx_ready && cap_n < 256) begin
      cap_d[cap_n] = tx_data; cap_s[cap_n] = tx_sof; cap_e[cap_n] = tx_eof;
      cap_n++;
    end
    if (filt_we && fcap_n < 32) begin
      fcap_d[fcap_n] = filt_data; fcap_a[fcap_n] = filt_addr; fcap_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + 7 * i) & 255);
  endfunction

  task automatic fill_buf(input int addr, input int n, input int seed);
    for (int i = 0; i < n; i++)
      mem[(addr + i) >> 2][8*((addr + i) % 4) +: 8] = pat(seed, i);
  endtask

  task automatic put_desc(input int addr, input logic [31:0] w0, input logic [31:0] ctl, input logic [31:0] buf_a);
    mem[addr >> 2]       = w0;
    mem[(addr >> 2) + 1] = ctl;
    mem[(addr >> 2) + 2] = buf_a;
    mem[(addr >> 2) + 3] = 32'h0;
  endtask

  task automatic restart();
    @(negedge clk); run_en = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    cap_n = 0; fcap_n = 0; rdy_mask = 8'hFF;
  endtask

  task automatic wait_park(input string tag);
    int k;
    k = 0;
    @(negedge clk);
    while (run_state != 2'b11 && k < 5000) begin @(negedge clk); k++; end
    chk(run_state == 2'b11, tag, {30'h0, run_state}, 32'h3);
  endtask

  task automatic go(input string tag);
    @(negedge clk); run_en = 1'b1;
    wait_park(tag);
    run_en = 1'b0;
  endtask

  task automatic chk_bytes(input string tag, input int base_i, input int n, input int seed);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) if (cap_d[base_i + i] !== pat(seed, i)) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic chk_marks(input string tag, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (cap_s[i] !== (i == 0)) bad++;
      if (cap_e[i] !== (i == n - 1)) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(run_state == 2'b00, "R1 reset run_state", {30'h0, run_state}, 0);
    chk(!tx_valid && !mem_rd_en && !mem_wr_en, "R1 reset quiet",
        {29'h0, tx_valid, mem_rd_en, mem_wr_en}, 0);
    chk(!tx_irq, "R9 reset irq", {31'h0, tx_irq}, 0);

    // table of single-descriptor frames: R4 R5 R6 R2 R9
    for (int v = 0; v < 6; v++) begin
      int n, seed;
      logic ic;
      restart();
      n    = int'(VEC[v][31:16]);
      seed = v * 17 + 3;
      ic   = VEC[v][0];
      fill_buf(32'h200, n, seed);
      put_desc(0, OWNED, F_FIRST | F_LAST | (ic ? F_IRQ : 32'h0) | 32'(n), 32'h200);
      rdy_mask = VEC[v][15:8];
      go("R3 table park");
      chk(cap_n == n, "R4 byte count", cap_n, n);
      chk_bytes("R4 R6 byte data", 0, n, seed);
      chk_marks("R5 markers", n);
      chk(mem[0] == 32'h0, "R2 handback", mem[0], 0);
      chk(tx_irq == ic, "R9 irq on completion", {31'h0, tx_irq}, {31'h0, ic});
    end

    // R9 write-one clear
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(!tx_irq, "R9 clear", {31'h0, tx_irq}, 0);

    // R2 R3 host-owned descriptor, then poll
    restart();
    put_desc(0, 32'h0000_1234, F_FIRST | F_LAST | 32'd6, 32'h200);
    go("R3 park on host owned");
    chk(mem[0] == 32'h0000_1234, "R2 no write to host owned", mem[0], 32'h1234);
    fill_buf(32'h200, 6, 40);
    put_desc(0, OWNED, F_FIRST | F_LAST | 32'd6, 32'h200);
    repeat (20) @(negedge clk);
    chk(cap_n == 0, "R3 no progress without poll", cap_n, 0);
    chk(run_state == 2'b11, "R3 still parked", {30'h0, run_state}, 32'h3);
    poll_dmd = 1'b1; @(negedge clk); poll_dmd = 1'b0;
    wait_park("R3 park after poll");
    chk(cap_n == 6, "R3 same descriptor re-read", cap_n, 6);
    chk_bytes("R3 data after poll", 0, 6, 40);
    chk(mem[0] == 32'h0, "R2 handback after poll", mem[0], 0);

    // R5 R7 two segments around a chain link
    restart();
    fill_buf(32'h200, 5, 11);
    fill_buf(32'h240, 6, 11 + 35);
    put_desc(32'h000, OWNED, F_FIRST | 32'd5, 32'h200);
    put_desc(32'h010, OWNED, F_LINK, 32'h100);
    put_desc(32'h100, OWNED, F_LAST | 32'd6, 32'h240);
    rdy_mask = 8'hB6;
    go("R7 park after chain");
    chk(cap_n == 11, "R5 joined length", cap_n, 11);
    chk_bytes("R5 joined data", 0, 11, 11);
    chk_marks("R5 one sof one eof", 11);
    chk(mem[4] == OWNED, "R7 link not handed back", mem[4], OWNED);
    chk(mem[0] == 32'h0 && mem[64] == 32'h0, "R2 both segments handed back", mem[64], 0);

    // R8 setup descriptor
    restart();
    for (int k = 0; k < 32; k++) mem[(32'h200 >> 2) + k] = 32'hA500_0000 + 32'(k * 3);
    put_desc(0, OWNED, F_SETUP | F_IRQ | 32'd128, 32'h200);
    go("R8 park after setup");
    chk(fcap_n == 32, "R8 filter word count", fcap_n, 32);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 32; k++)
        if (fcap_d[k] !== 32'hA500_0000 + 32'(k * 3) || fcap_a[k] !== 5'(k)) bad++;
      chk(bad == 0, "R8 filter contents", bad, 0);
    end
    chk(cap_n == 0, "R8 nothing streamed", cap_n, 0);
    chk(mem[0] == 32'h0, "R8 setup handed back", mem[0], 0);
    chk(tx_irq, "R9 irq from setup", {31'h0, tx_irq}, 1);

    // R1 soft reset mid-frame, restart from base
    restart();
    fill_buf(32'h200, 64, 90);
    put_desc(0, OWNED, F_FIRST | F_LAST | 32'd64, 32'h200);
    rdy_mask = 8'h01;
    @(negedge clk); run_en = 1'b1;
    repeat (40) @(negedge clk);
    run_en = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(run_state == 2'b00 && !tx_valid, "R1 soft reset idle",
        {29'h0, run_state, tx_valid}, 0);
    chk(mem[0] == OWNED, "R1 aborted descriptor kept", mem[0], OWNED);
    cap_n = 0; rdy_mask = 8'hFF;
    go("R1 park after restart");
    chk(cap_n == 64, "R1 restart from base", cap_n, 64);
    chk_bytes("R1 restart data", 0, 64, 90);
    chk(cap_s[0] === 1'b1, "R5 sof after restart", {31'h0, cap_s[0]}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule